// File: doc/BRIEF.md
# Range-Match Translation Buffer

This block holds a small, fully associative set of address translations. Each slot covers one virtual page. It stores the page's first and last virtual address, a physical page number and a protection attribute set. A permission checker downstream presents a virtual address on the lookup pins. Within the same cycle it receives either a miss or the matching slot's physical address and attributes. The buffer itself applies no permission policy.

Software loads a translation in two commands. The first command carries the virtual address and the physical page number. It places an invalid slot. The second command carries the protection word for the same page. It decodes the attributes and marks the slot valid. Two more commands remove translations: one purges the slot covering a given address, and the other clears the whole array.

When a slot must be chosen, a free or just-cleared slot is preferred. If none exists, a round-robin victim pointer picks the slot. Every command completes in one clock, so `cmd_ready` is held high at all times and a command is taken on every cycle in which `cmd_valid` is high. Lookups have no handshake; they are evaluated continuously.

Top module: `range_tlb`

## Requirements
- R1: A slot matches a lookup address when its begin address is less than or equal to the address and its end address is greater than or equal to it. When the selected slot is valid, `lk_hit` is 1, `lk_idx` gives the slot, and `lk_pa` is the slot's physical page number followed by the low page-offset bits of `lk_addr`. On a miss, `lk_hit` and all attribute outputs are 0.
- R2: When several slots match an address, the lowest-numbered one is selected, for lookups and for every command. If that slot is invalid, the lookup misses even when a higher-numbered valid slot also matches.
- R3: An address insert (`cmd_op`=0) first clears every valid slot that covers `cmd_addr`. Its target is the highest-numbered slot that is either invalid or cleared by this command.
- R4: If an address insert finds no such slot, it writes the slot at the victim pointer. The pointer then advances by one and wraps from the last slot to slot 0.
- R5: An address insert sets the target's begin address to `cmd_addr` with the page-offset bits cleared and its end address to that value plus the page size minus one. It takes the physical page number from `cmd_data` bits 24:5, clears the attributes, and leaves the slot invalid.
- R6: A protection insert (`cmd_op`=1) acts on the lowest covering slot when that slot is invalid. It loads the access id from bits 18:1, the user bit from 19, privilege level 2 from 21:20, privilege level 1 from 23:22, the access kind from 26:24, the break bit from 27, the dirty bit from 28 and the trap bit from 29, then marks the slot valid.
- R7: A protection insert with no covering slot, or whose covering slot is already valid, changes nothing. `prot_err` is then 1 for exactly the one cycle after the accepting edge.
- R8: A single purge (`cmd_op`=2) clears the lowest covering slot only if it is valid. Otherwise it changes nothing.
- R9: A purge-all (`cmd_op`=3) clears every slot in one cycle.
- R10: A cleared slot holds an all-ones begin address and a zero end address, so it matches no lookup, including address all-ones.
- R11: Lookups are combinational on the stored state, and commands take effect at the clock edge. A lookup in the same cycle as a command sees the state from before that command. `cmd_ready` is always 1.
- R12: After reset every slot is cleared, the victim pointer is 0 and `prot_err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted (always 1) |
| cmd_op | input | 2 | 0 address insert, 1 protection insert, 2 purge, 3 purge all |
| cmd_addr | input | VA_W | Virtual address operand |
| cmd_data | input | 32 | Physical page or protection word operand |
| lk_addr | input | VA_W | Lookup virtual address |
| lk_hit | output | 1 | Valid translation found |
| lk_idx | output | IDX_W | Selected slot |
| lk_pa | output | PPN_W+PAGE_W | Physical address |
| lk_acc_id | output | 18 | Access id |
| lk_user | output | 1 | User bit |
| lk_pl2 | output | 2 | Privilege level 2 |
| lk_pl1 | output | 2 | Privilege level 1 |
| lk_kind | output | 3 | Access kind |
| lk_brk | output | 1 | Break bit |
| lk_dirty | output | 1 | Dirty bit |
| lk_trap | output | 1 | Trap bit |
| prot_err | output | 1 | Rejected protection insert, one-cycle pulse |

## Verification
A lookup and a command that rewrites the same slot can fall in the same cycle. Examples are a purge of the address being looked up, and an address insert that evicts or re-creates the looked-up page. The bench sets `lk_addr` equal to `cmd_addr` on such commands. It expects the lookup to report the pre-edge slot in that cycle and the updated slot in the following cycle. It also drives many commands to one small pool of pages at random, so that clearing and slot selection coincide inside a single address insert, and duplicate invalid slots arise.

// File: rtl/range_tlb_pkg.sv
package range_tlb_pkg;

  typedef enum logic [1:0] {
    OP_MAP_ADDR = 2'd0,
    OP_MAP_PROT = 2'd1,
    OP_DROP_ONE = 2'd2,
    OP_DROP_ALL = 2'd3
  } tlb_op_e;

  typedef struct packed {
    logic [17:0] acc_id;
    logic        user;
    logic [1:0]  pl2;
    logic [1:0]  pl1;
    logic [2:0]  kind;
    logic        brk;
    logic        dirty;
    logic        trap;
  } tlb_attr_t;

  // protection word layout: neighbours decode these positions
  function automatic tlb_attr_t unpack_prot(input logic [31:0] w);
    tlb_attr_t a;
    a.acc_id = w[18:1];
    a.user   = w[19];
    a.pl2    = w[21:20];
    a.pl1    = w[23:22];
    a.kind   = w[26:24];
    a.brk    = w[27];
    a.dirty  = w[28];
    a.trap   = w[29];
    return a;
  endfunction

endpackage

// File: rtl/range_tlb_match.sv
module range_tlb_match #(
  parameter int N    = 8,
  parameter int VA_W = 32,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0][VA_W-1:0] beg_vec,
  input  logic [N-1:0][VA_W-1:0] end_vec,
  input  logic [VA_W-1:0]        addr,
  output logic [N-1:0]           hit_vec,
  output logic                   any,
  output logic [IDX_W-1:0]       first
);

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_vec[g] = (beg_vec[g] <= addr) && (end_vec[g] >= addr);
  end

  assign any = |hit_vec;

  // lowest index wins: scan downward so the last write is the lowest hit
  always_comb begin
    first = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit_vec[i]) first = IDX_W'(i);
    end
  end

endmodule

// File: rtl/range_tlb_slot_pick.sv
module range_tlb_slot_pick #(
  parameter int N = 8,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     valid_vec,
  input  logic [N-1:0]     cover_vec,
  output logic [N-1:0]     clear_vec,
  output logic             tgt_found,
  output logic [IDX_W-1:0] tgt_idx
);

  for (genvar g = 0; g < N; g++) begin : g_clr
    assign clear_vec[g] = valid_vec[g] & cover_vec[g];
  end

  // highest slot that is free or freed by this command
  always_comb begin
    tgt_found = 1'b0;
    tgt_idx   = '0;
    for (int i = 0; i < N; i++) begin
      if (!valid_vec[i] || clear_vec[i]) begin
        tgt_found = 1'b1;
        tgt_idx   = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/range_tlb_store.sv
module range_tlb_store
  import range_tlb_pkg::*;
#(
  parameter int N      = 8,
  parameter int VA_W   = 32,
  parameter int PAGE_W = 12,
  parameter int PPN_W  = 20,
  localparam int IDX_W = $clog2(N),
  localparam int VPN_W = VA_W - PAGE_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cmd_valid,
  input  tlb_op_e                cmd_op,
  input  logic [VPN_W-1:0]       cmd_vpn,
  input  logic [PPN_W-1:0]       new_ppn,
  input  tlb_attr_t              new_attr,
  input  logic                   cmd_any,
  input  logic [IDX_W-1:0]       cmd_first,
  input  logic [N-1:0]           clear_vec,
  input  logic                   tgt_found,
  input  logic [IDX_W-1:0]       tgt_idx,
  output logic [N-1:0][VA_W-1:0] beg_vec,
  output logic [N-1:0][VA_W-1:0] end_vec,
  output logic [N-1:0][PPN_W-1:0] ppn_vec,
  output tlb_attr_t [N-1:0]      attr_vec,
  output logic [N-1:0]           valid_vec,
  output logic [IDX_W-1:0]       rr_ptr,
  output logic                   prot_err
);

  logic [IDX_W-1:0] slot_w;
  logic [IDX_W-1:0] rr_next;
  logic             prot_ok;

  assign slot_w  = tgt_found ? tgt_idx : rr_ptr;
  assign rr_next = (rr_ptr == IDX_W'(N - 1)) ? '0 : rr_ptr + 1'b1;
  assign prot_ok = cmd_any && !valid_vec[cmd_first];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        beg_vec[i]   <= '1;
        end_vec[i]   <= '0;
        ppn_vec[i]   <= '0;
        attr_vec[i]  <= '0;
        valid_vec[i] <= 1'b0;
      end
      rr_ptr   <= '0;
      prot_err <= 1'b0;
    end else begin
      prot_err <= 1'b0;
      if (cmd_valid) begin
        unique case (cmd_op)
          OP_MAP_ADDR: begin
            for (int i = 0; i < N; i++) begin
              if (clear_vec[i]) begin
                beg_vec[i]   <= '1;
                end_vec[i]   <= '0;
                ppn_vec[i]   <= '0;
                attr_vec[i]  <= '0;
                valid_vec[i] <= 1'b0;
              end
            end
            if (!tgt_found) rr_ptr <= rr_next;
            beg_vec[slot_w]   <= {cmd_vpn, {PAGE_W{1'b0}}};
            end_vec[slot_w]   <= {cmd_vpn, {PAGE_W{1'b1}}};
            ppn_vec[slot_w]   <= new_ppn;
            attr_vec[slot_w]  <= '0;
            valid_vec[slot_w] <= 1'b0;
          end
          OP_MAP_PROT: begin
            if (prot_ok) begin
              attr_vec[cmd_first]  <= new_attr;
              valid_vec[cmd_first] <= 1'b1;
            end else begin
              prot_err <= 1'b1;
            end
          end
          OP_DROP_ONE: begin
            if (cmd_any && valid_vec[cmd_first]) begin
              beg_vec[cmd_first]   <= '1;
              end_vec[cmd_first]   <= '0;
              ppn_vec[cmd_first]   <= '0;
              attr_vec[cmd_first]  <= '0;
              valid_vec[cmd_first] <= 1'b0;
            end
          end
          OP_DROP_ALL: begin
            for (int i = 0; i < N; i++) begin
              beg_vec[i]   <= '1;
              end_vec[i]   <= '0;
              ppn_vec[i]   <= '0;
              attr_vec[i]  <= '0;
              valid_vec[i] <= 1'b0;
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/range_tlb.sv
module range_tlb
  import range_tlb_pkg::*;
#(
  parameter int N       = 8,
  parameter int VA_W    = 32,
  parameter int PAGE_W  = 12,
  parameter int PPN_W   = 20,
  parameter int PPN_LSB = 5,
  localparam int IDX_W  = $clog2(N),
  localparam int PA_W   = PPN_W + PAGE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [VA_W-1:0]   cmd_addr,
  input  logic [31:0]       cmd_data,
  input  logic [VA_W-1:0]   lk_addr,
  output logic              lk_hit,
  output logic [IDX_W-1:0]  lk_idx,
  output logic [PA_W-1:0]   lk_pa,
  output logic [17:0]       lk_acc_id,
  output logic              lk_user,
  output logic [1:0]        lk_pl2,
  output logic [1:0]        lk_pl1,
  output logic [2:0]        lk_kind,
  output logic              lk_brk,
  output logic              lk_dirty,
  output logic              lk_trap
  ,
  output logic              prot_err
);

  logic [N-1:0][VA_W-1:0]  beg_vec;
  logic [N-1:0][VA_W-1:0]  end_vec;
  logic [N-1:0][PPN_W-1:0] ppn_vec;
  tlb_attr_t [N-1:0]       attr_vec;
  logic [N-1:0]            valid_vec;
  logic [IDX_W-1:0]        rr_ptr;

  logic [N-1:0]            lk_vec;
  logic                    lk_any;
  logic [IDX_W-1:0]        lk_first;
  logic [N-1:0]            cmd_vec;
  logic                    cmd_any;
  logic [IDX_W-1:0]        cmd_first;
  logic [N-1:0]            clear_vec;
  logic                    tgt_found;
  logic [IDX_W-1:0]        tgt_idx;
  tlb_attr_t               new_attr;
  tlb_attr_t               sel_attr;
  logic [PPN_W-1:0]        new_ppn;

  assign cmd_ready = 1'b1;
  assign new_attr  = unpack_prot(cmd_data);
  assign new_ppn   = cmd_data[PPN_LSB +: PPN_W];

  range_tlb_match #(.N(N), .VA_W(VA_W)) u_lk_match (
    .beg_vec (beg_vec),
    .end_vec (end_vec),
    .addr    (lk_addr),
    .hit_vec (lk_vec),
    .any     (lk_any),
    .first   (lk_first)
  );

  range_tlb_match #(.N(N), .VA_W(VA_W)) u_cmd_match (
    .beg_vec (beg_vec),
    .end_vec (end_vec),
    .addr    (cmd_addr),
    .hit_vec (cmd_vec),
    .any     (cmd_any),
    .first   (cmd_first)
  );

  range_tlb_slot_pick #(.N(N)) u_pick (
    .valid_vec (valid_vec),
    .cover_vec (cmd_vec),
    .clear_vec (clear_vec),
    .tgt_found (tgt_found),
    .tgt_idx   (tgt_idx)
  );

  range_tlb_store #(
    .N(N), .VA_W(VA_W), .PAGE_W(PAGE_W), .PPN_W(PPN_W)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (tlb_op_e'(cmd_op)),
    .cmd_vpn   (cmd_addr[VA_W-1:PAGE_W]),
    .new_ppn   (new_ppn),
    .new_attr  (new_attr),
    .cmd_any   (cmd_any),
    .cmd_first (cmd_first),
    .clear_vec (clear_vec),
    .tgt_found (tgt_found),
    .tgt_idx   (tgt_idx),
    .beg_vec   (beg_vec),
    .end_vec   (end_vec),
    .ppn_vec   (ppn_vec),
    .attr_vec  (attr_vec),
    .valid_vec (valid_vec),
    .rr_ptr    (rr_ptr),
    .prot_err  (prot_err)
  );

  assign lk_hit   = lk_any && valid_vec[lk_first];
  assign lk_idx   = lk_first;
  assign lk_pa    = lk_hit ? {ppn_vec[lk_first], lk_addr[PAGE_W-1:0]} : '0;
  assign sel_attr = lk_hit ? attr_vec[lk_first] : '0;

  assign lk_acc_id = sel_attr.acc_id;
  assign lk_user   = sel_attr.user;
  assign lk_pl2    = sel_attr.pl2;
  assign lk_pl1    = sel_attr.pl1;
  assign lk_kind   = sel_attr.kind;
  assign lk_brk    = sel_attr.brk;
  assign lk_dirty  = sel_attr.dirty;
  assign lk_trap   = sel_attr.trap;

endmodule

// File: rtl/range_tlb_checker.sv
module range_tlb_checker #(
  parameter int N    = 8,
  parameter int VA_W = 32,
  localparam int IDX_W = $clog2(N)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cmd_valid,
  input logic [1:0]             cmd_op,
  input logic [N-1:0]           valid_vec,
  input logic [IDX_W-1:0]       rr_ptr,
  input logic                   tgt_found,
  input logic                   prot_err,
  input logic                   lk_hit,
  input logic [IDX_W-1:0]       lk_idx,
  input logic [VA_W-1:0]        lk_addr,
  input logic [N-1:0][VA_W-1:0] beg_vec,
  input logic [N-1:0][VA_W-1:0] end_vec
);

  AST_HIT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (beg_vec[lk_idx] <= lk_addr && end_vec[lk_idx] >= lk_addr)); // R1

  AST_MAP_NO_GROWTH: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'd0) |=>
      ($countones(valid_vec) <= $past($countones(valid_vec)))); // R3

  AST_VICTIM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'd0 && !tgt_found) |=>
      (rr_ptr == (($past(rr_ptr) == IDX_W'(N - 1)) ? '0 : $past(rr_ptr) + 1'b1))); // R4

  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    prot_err |-> $past(cmd_valid && cmd_op == 2'd1)); // R7

  AST_DROP_ALL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'd3) |=> (valid_vec == '0 && !lk_hit)); // R9

endmodule

bind range_tlb range_tlb_checker #(.N(N), .VA_W(VA_W)) u_range_tlb_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_op    (cmd_op),
  .valid_vec (valid_vec),
  .rr_ptr    (rr_ptr),
  .tgt_found (tgt_found),
  .prot_err  (prot_err),
  .lk_hit    (lk_hit),
  .lk_idx    (lk_idx),
  .lk_addr   (lk_addr),
  .beg_vec   (beg_vec),
  .end_vec   (end_vec)
);

// File: tb/test_range_tlb.sv
`timescale 1ns/1ps
module test_range_tlb;

  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [1:0]  cmd_op = '0;
  logic [31:0] cmd_addr = '0;
  logic [31:0] cmd_data = '0;
  logic [31:0] lk_addr = '0;
  logic        lk_hit;
  logic [2:0]  lk_idx;
  logic [31:0] lk_pa;
  logic [17:0] lk_acc_id;
  logic        lk_user;
  logic [1:0]  lk_pl2, lk_pl1;
  logic [2:0]  lk_kind;
  logic        lk_brk, lk_dirty, lk_trap;
  logic        prot_err;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // behavioural reference state
  logic [31:0] m_beg [N];
  logic [31:0] m_end [N];
  logic [19:0] m_ppn [N];
  logic [31:0] m_word [N];
  bit          m_val [N];
  int          m_rr;
  bit          m_err;

  always #10 clk = ~clk;

  range_tlb i_range_tlb (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_idx(lk_idx), .lk_pa(lk_pa),
    .lk_acc_id(lk_acc_id), .lk_user(lk_user), .lk_pl2(lk_pl2), .lk_pl1(lk_pl1),
    .lk_kind(lk_kind), .lk_brk(lk_brk), .lk_dirty(lk_dirty), .lk_trap(lk_trap),
    .prot_err(prot_err)
  );

  function automatic void m_wipe(int i);
    m_beg[i] = 32'hFFFF_FFFF; m_end[i] = '0; m_ppn[i] = '0;
    m_word[i] = '0; m_val[i] = 0;
  endfunction

  function automatic int m_find(logic [31:0] a);
    for (int i = 0; i < N; i++)
      if (m_beg[i] <= a && a <= m_end[i]) return i;
    return -1;
  endfunction

  function automatic void m_step(bit v, logic [1:0] op, logic [31:0] a, logic [31:0] d);
    int f, t;
    m_err = 0;
    if (!v) return;
    f = m_find(a);
    case (op)
      2'd0: begin
        t = -1;
        for (int i = 0; i < N; i++) begin
          if (!m_val[i]) t = i;
          else if (m_beg[i] <= a && a <= m_end[i]) begin m_wipe(i); t = i; end
        end
        if (t < 0) begin t = m_rr; m_rr = (m_rr + 1) % N; end
        m_beg[t] = {a[31:12], 12'h000};
        m_end[t] = {a[31:12], 12'hFFF};
        m_ppn[t] = d[24:5];
        m_word[t] = '0;
        m_val[t] = 0;
      end
      2'd1: begin
        if (f < 0 || m_val[f]) m_err = 1;
        else begin m_word[f] = d; m_val[f] = 1; end
      end
      2'd2: if (f >= 0 && m_val[f]) m_wipe(f);
      default: for (int i = 0; i < N; i++) m_wipe(i);
    endcase
  endfunction

  task automatic compare(string tag);
    int f;
    bit eh;
    logic [31:0] w;
    logic [28:0] exp_attr, act_attr;
    f = m_find(lk_addr);
    eh = (f >= 0) && m_val[f];
    checks++;
    if (lk_hit !== eh || cmd_ready !== 1'b1 ||
        (eh && (lk_idx !== f[2:0] || lk_pa !== {m_ppn[f], lk_addr[11:0]}))) begin
      errors++;
      $display("FAIL %s lookup %h: hit/idx/pa/rdy actual %b/%0d/%h/%b expected %b/%0d/%h/1",
               tag, lk_addr, lk_hit, lk_idx, lk_pa, cmd_ready, eh, f,
               eh ? {m_ppn[f], lk_addr[11:0]} : 32'h0);
    end
    w = eh ? m_word[f] : 32'h0;
    exp_attr = {w[18:1], w[19], w[21:20], w[23:22], w[26:24], w[27], w[28], w[29]};
    act_attr = {lk_acc_id, lk_user, lk_pl2, lk_pl1, lk_kind, lk_brk, lk_dirty, lk_trap};
    checks++;
    if (act_attr !== exp_attr || (!eh && lk_pa !== 32'h0)) begin
      errors++;
      $display("FAIL %s attributes at %h: actual %h expected %h", tag, lk_addr, act_attr, exp_attr);
    end
    checks++;
    if (prot_err !== m_err) begin
      errors++;
      $display("FAIL %s prot_err actual %b expected %b", tag, prot_err, m_err);
    end
  endtask

  task automatic cyc(bit v, logic [1:0] op, logic [31:0] a, logic [31:0] d,
                     logic [31:0] la, string tag);
    @(negedge clk);
    cmd_valid = v; cmd_op = op; cmd_addr = a; cmd_data = d; lk_addr = la;
    #5;
    compare(tag);
    @(posedge clk);
    m_step(v, op, a, d);
  endtask

  function automatic logic [31:0] pw(int acc, bit u, int p2, int p1, int k, bit b, bit dd, bit t);
    logic [31:0] w = '0;
    w[18:1] = acc[17:0]; w[19] = u; w[21:20] = p2[1:0]; w[23:22] = p1[1:0];
    w[26:24] = k[2:0]; w[27] = b; w[28] = dd; w[29] = t;
    return w;
  endfunction

  task automatic map(logic [31:0] a, logic [19:0] ppn, string tag);
    cyc(1, 2'd0, a, {7'h0, ppn, 5'h0}, a, tag);
  endtask
  task automatic prot(logic [31:0] a, logic [31:0] w, string tag);
    cyc(1, 2'd1, a, w, a, tag);
  endtask
  task automatic drop(logic [31:0] a, string tag);
    cyc(1, 2'd2, a, 32'h0, a, tag);
  endtask
  task automatic look(logic [31:0] a, string tag);
    cyc(0, 2'd0, 32'h0, 32'h0, a, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired before completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) m_wipe(i);
    m_rr = 0; m_err = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    look(32'h0000_0000, "R12 reset");
    look(32'hFFFF_FFFF, "R10 all-ones after reset");

    // first insert lands in the highest free slot; same-cycle lookup sees old state
    map(32'h0001_0234, 20'hABCDE, "R11 insert with lookup");
    look(32'h0001_0FFF, "R5 entry invalid after address insert");
    prot(32'h0001_0800, pw(18'h2A5A5, 1, 2, 1, 5, 1, 0, 1), "R6 protection insert");
    look(32'h0001_0ABC, "R1 hit with fields");
    look(32'h0001_1000, "R5 end bound");
    look(32'h0000_FFFF, "R5 begin bound");
    prot(32'h0001_0000, pw(1, 0, 0, 0, 1, 0, 1, 0), "R7 already valid");
    look(32'h0001_0000, "R7 fields unchanged");
    prot(32'h0077_7000, pw(3, 1, 1, 1, 3, 1, 1, 1), "R7 no covering slot");
    look(32'h0077_7000, "R7 after error");

    // fill the rest, then force round-robin victims with wrap
    for (int k = 0; k < N - 1; k++) begin
      map(32'h0010_0000 + k * 32'h1000, 20'h00100 + k[19:0], "R3 fill");
      prot(32'h0010_0000 + k * 32'h1000, pw(k + 7, k[0], k % 4, 3 - (k % 4), k % 8, 0, 1, 0), "R6 fill");
    end
    for (int k = 0; k < N + 2; k++) begin
      map(32'h0020_0000 + k * 32'h1000, 20'h00200 + k[19:0], "R4 victim");
      look(32'h0020_0000 + k * 32'h1000, "R4 victim invalid");
      prot(32'h0020_0000 + k * 32'h1000, pw(k, 1, 0, 3, 2, 0, 0, 0), "R4 victim fill");
    end

    // re-mapping a valid page clears it and reuses that slot
    cyc(1, 2'd0, 32'h0020_9000, {7'h0, 20'h55555, 5'h0}, 32'h0020_9000, "R3 remap same cycle");
    look(32'h0020_9000, "R3 remap cleared");
    prot(32'h0020_9000, pw(9, 0, 1, 2, 3, 0, 1, 1), "R3 remap validate");
    look(32'h0020_9123, "R3 remap hit");

    // single purge, same-cycle lookup, then a purge that finds nothing valid
    drop(32'h0020_9000, "R11 purge with lookup");
    look(32'h0020_9000, "R8 purged");
    drop(32'h0020_9000, "R8 purge of absent page");
    look(32'h0020_8000, "R8 neighbour intact");

    // duplicate invalid slots: lowest covering slot wins
    cyc(1, 2'd3, 32'h0, 32'h0, 32'h0020_8000, "R9 purge all");
    look(32'h0020_8000, "R9 all cleared");
    look(32'hFFFF_FFFF, "R10 cleared slot");
    for (int k = 0; k < 4; k++) begin
      map(32'h0030_0000 + k * 32'h1000, 20'h00300 + k[19:0], "R3 upper slots");
      prot(32'h0030_0000 + k * 32'h1000, pw(k, 0, 0, 0, 1, 0, 0, 0), "R6 upper slots");
    end
    map(32'h0040_0000, 20'h00401, "R2 first copy");
    drop(32'h0030_0000, "R8 free top slot");
    map(32'h0040_0000, 20'h00402, "R2 second copy");
    look(32'h0040_0000, "R2 lowest invalid hides higher");
    prot(32'h0040_0000, pw(17, 1, 3, 3, 7, 1, 1, 1), "R2 protection to lowest");
    look(32'h0040_0456, "R2 lowest wins");
    prot(32'h0040_0000, pw(1, 0, 0, 0, 0, 0, 0, 0), "R2 lowest valid rejects");
    look(32'h0040_0000, "R7 pulse one cycle");
    drop(32'h0040_0000, "R8 purge lowest");
    look(32'h0040_0000, "R2 higher copy still invalid");
    drop(32'h0040_0000, "R8 purge of invalid copy");
    prot(32'h0040_0000, pw(2, 0, 0, 0, 3, 0, 0, 0), "R6 higher copy validated");
    look(32'h0040_0010, "R1 higher copy hit");

    // random traffic over a small page pool with coincident lookups
    for (int n = 0; n < 600; n++) begin
      logic [31:0] a, la, d;
      logic [1:0] op;
      int r;
      a  = {20'h00500 + 20'($urandom_range(0, 11)), 12'($urandom)};
      la = ($urandom_range(0, 2) == 0) ? a
           : {20'h00500 + 20'($urandom_range(0, 11)), 12'($urandom)};
      d  = $urandom;
      r  = $urandom_range(0, 99);
      op = (r < 35) ? 2'd0 : (r < 75) ? 2'd1 : (r < 97) ? 2'd2 : 2'd3;
      cyc($urandom_range(0, 4) != 0, op, a, d, la, "R1 random traffic");
    end

    look(32'h0, "R1 final");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule